// File: doc/BRIEF.md
# Low-Toggle Pseudo-Random Scan Stimulus Generator

This block feeds the scan-chain inputs of a logic self-test with pseudo-random stimulus whose average switching activity can be set in advance. A 16-bit shift-register generator provides a few raw pseudo-random streams, and each of these would toggle in about half of all cycles. Every stream passes through its own hold register. A second, independent shift-register generator decides in each cycle whether each hold register takes a new value or keeps its old one. A small XOR network then widens the held streams into 32 chain inputs.

A 4-bit activity code sets how often the hold registers are allowed to update. The lowest code makes updates rare, and so gives few transitions. The highest code lets every register update in every cycle, which gives the full rate of about 50%. Software loads a seed once. A start pulse replays the same sequence from that seed. While enable is low, the whole generator keeps its state.

Top module: `ltp_prpg`

## Requirements
- R1: A synchronous reset sets the stored seed and the main generator to 16'hACE1, sets the auxiliary generator to 32'hC0DE1357, and loads hold register i with bit i of 16'hACE1.
- R2: In each enabled cycle without a restart, the main generator s becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. It never holds zero.
- R3: A seed_ld pulse stores `seed` (a value of zero is stored as 1), loads the main generator with the stored value, loads the auxiliary generator with 32'hC0DE1357, and loads hold bit i with bit i of the stored value. seed_ld takes priority over start and over enable.
- R4: A start pulse (without seed_ld) performs the same restart, using the stored seed.
- R5: While en is low and no restart occurs, the generators and hold registers keep their values, so chain_si does not change.
- R6: In an enabled cycle, hold register i (0 to 7) takes bit i of the main generator when the auxiliary slice aux[4i+3:4i] is less than or equal to `target`. Otherwise it keeps its value.
- R7: In each enabled cycle without a restart, the auxiliary generator a becomes {a[30:0], a[31]^a[21]^a[1]^a[0]}.
- R8: chain_si[j] = h[x]^h[y] for j<16 and h[x]^h[y]^h[z] for j≥16, where h is the hold vector, x=j mod 8, y=(x+1+j/8) mod 8 and z=(x+5+(j/8) mod 2) mod 8. The output is combinational from the hold registers.
- R9: With target 15, every hold register updates in every enabled cycle. Over 4096 cycles, the fraction of chain bits that toggle lies between 45% and 55%.
- R10: Over 4096 enabled cycles following a restart, the total number of chain toggles rises strictly as target steps through 0, 3, 7, 11 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance generators and hold registers |
| start | input | 1 | Restart the sequence from the stored seed |
| seed_ld | input | 1 | Store `seed` and restart from it |
| seed | input | 16 | Seed value for the main generator |
| target | input | 4 | Activity code, 0 (lowest) to 15 (full rate) |
| chain_si | output | 32 | Scan-chain input streams |

## Verification
Each control edge (reset, seed_ld, start or an enabled step) acts at one clock edge, and its effect reaches chain_si in that same cycle, because the phase network is combinational from the hold registers. A behavioural model in the bench advances on the same clock edge as the design, and the comparison is made on the following falling edge, so every expected value is due exactly one edge after the inputs that caused it. The toggle-rate checks take chain_si on falling edges across 4096 enabled cycles after a restart, so each run for a given code starts from the same known state.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

   // Feedback mask for a left-shifting Fibonacci register of the given width.
   // Bit k set means stage k takes part in the XOR feedback.
   function automatic logic [63:0] taps_for(input int w);
      case (w)
         16:      return 64'h0000_0000_0000_B400;
         24:      return 64'h0000_0000_00E1_0000;
         32:      return 64'h0000_0000_8020_0003;
         48:      return 64'h0000_C000_0018_0000;
         64:      return 64'hD800_0000_0000_0000;
         default: return 64'h0;
      endcase
   endfunction

   function automatic bit width_ok(input int w);
      return taps_for(w) != 64'h0;
   endfunction

   // Phase network source indices for chain j given g hold registers.
   function automatic int src_x(input int j, input int g);
      return j % g;
   endfunction

   function automatic int src_y(input int j, input int g);
      return (j % g + 1 + (j / g) % 4) % g;
   endfunction

   function automatic int src_z(input int j, input int g);
      return (j % g + 5 + (j / g) % 2) % g;
   endfunction

endpackage

// File: rtl/ltp_lfsr.sv
module ltp_lfsr #(
   parameter int           W    = 16,
   parameter logic [W-1:0] TAPS = '1,
   parameter logic [W-1:0] INIT = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   logic fb;

   assign fb = ^(q & TAPS);

   always_ff @(posedge clk) begin
      if (rst)     q <= INIT;
      else if (ld) q <= ld_val;
      else if (en) q <= {q[W-2:0], fb};
   end
endmodule

// File: rtl/ltp_hold_bank.sv
module ltp_hold_bank #(
   parameter int           G   = 8,
   parameter int           TW  = 4,
   parameter logic [G-1:0] RST = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          ld,
   input  logic [G-1:0]  ld_val,
   input  logic [G-1:0]  din,
   input  logic [G*TW-1:0] rng,
   input  logic [TW-1:0] target,
   output logic [G-1:0]  upd,
   output logic [G-1:0]  q
);
   for (genvar i = 0; i < G; i++) begin : g_bit
      assign upd[i] = rng[i*TW +: TW] <= target;

      always_ff @(posedge clk) begin
         if (rst)                 q[i] <= RST[i];
         else if (ld)             q[i] <= ld_val[i];
         else if (en && upd[i])   q[i] <= din[i];
      end
   end
endmodule

// File: rtl/ltp_phase_shift.sv
module ltp_phase_shift #(
   parameter int G = 8,
   parameter int N = 32
) (
   input  logic [G-1:0] h,
   output logic [N-1:0] o
);
   import ltp_pkg::*;

   for (genvar j = 0; j < N; j++) begin : g_chain
      localparam int X = src_x(j, G);
      localparam int Y = src_y(j, G);
      localparam int Z = src_z(j, G);
      if (j >= N / 2) begin : g_three
         assign o[j] = h[X] ^ h[Y] ^ h[Z];
      end else begin : g_two
         assign o[j] = h[X] ^ h[Y];
      end
   end
endmodule

// File: rtl/ltp_prpg.sv
module ltp_prpg #(
   parameter int                LW       = 16,
   parameter int                G        = 8,
   parameter int                TW       = 4,
   parameter int                N        = 32,
   parameter logic [LW-1:0]     DEF_SEED = 16'hACE1,
   parameter logic [G*TW-1:0]   AUX_SEED = 32'hC0DE_1357
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          start,
   input  logic          seed_ld,
   input  logic [LW-1:0] seed,
   input  logic [TW-1:0] target,
   output logic [N-1:0]  chain_si
);
   import ltp_pkg::*;

   localparam int AW = G * TW;
   localparam logic [LW-1:0] MAIN_TAPS = taps_for(LW)[LW-1:0];
   localparam logic [AW-1:0] AUX_TAPS  = taps_for(AW)[AW-1:0];

   if (!width_ok(LW)) begin : g_bad_lw
      $error("ltp_prpg: unsupported main generator width");
   end
   if (!width_ok(AW)) begin : g_bad_aw
      $error("ltp_prpg: G*TW must be a supported auxiliary width");
   end
   if (G < 8 || G > LW) begin : g_bad_g
      $error("ltp_prpg: G must lie in 8..LW");
   end
   if (DEF_SEED == '0 || AUX_SEED == '0) begin : g_bad_seed
      $error("ltp_prpg: seeds must be nonzero");
   end
   if (N < 2) begin : g_bad_n
      $error("ltp_prpg: N must be at least 2");
   end

   logic [LW-1:0] seed_r, seed_fix, rval, lfsr_q;
   logic [AW-1:0] aux_q;
   logic [G-1:0]  hold_q, upd;
   logic          restart;

   assign seed_fix = (seed == '0) ? {{(LW-1){1'b0}}, 1'b1} : seed;
   assign restart  = seed_ld | start;
   assign rval     = seed_ld ? seed_fix : seed_r;

   always_ff @(posedge clk) begin
      if (rst)          seed_r <= DEF_SEED;
      else if (seed_ld) seed_r <= seed_fix;
   end

   ltp_lfsr #(.W(LW), .TAPS(MAIN_TAPS), .INIT(DEF_SEED)) u_main (
      .clk(clk), .rst(rst), .en(en), .ld(restart), .ld_val(rval), .q(lfsr_q)
   );

   ltp_lfsr #(.W(AW), .TAPS(AUX_TAPS), .INIT(AUX_SEED)) u_aux (
      .clk(clk), .rst(rst), .en(en), .ld(restart), .ld_val(AUX_SEED), .q(aux_q)
   );

   ltp_hold_bank #(.G(G), .TW(TW), .RST(DEF_SEED[G-1:0])) u_hold (
      .clk(clk), .rst(rst), .en(en), .ld(restart), .ld_val(rval[G-1:0]),
      .din(lfsr_q[G-1:0]), .rng(aux_q), .target(target), .upd(upd), .q(hold_q)
   );

   ltp_phase_shift #(.G(G), .N(N)) u_ps (
      .h(hold_q), .o(chain_si)
   );
endmodule

// File: rtl/ltp_prpg_chk.sv
module ltp_prpg_chk #(
   parameter int LW = 16,
   parameter int G  = 8,
   parameter int TW = 4,
   parameter int N  = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          en,
   input logic          start,
   input logic          seed_ld,
   input logic [LW-1:0] seed,
   input logic [TW-1:0] target,
   input logic [N-1:0]  chain_si,
   input logic [LW-1:0] lfsr_q,
   input logic [LW-1:0] seed_r,
   input logic [G-1:0]  hold_q,
   input logic [G-1:0]  upd
);
   a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
      lfsr_q != '0);

   a_r3_zero_seed: assert property (@(posedge clk) disable iff (rst)
      (seed_ld && seed == '0) |=> lfsr_q == {{(LW-1){1'b0}}, 1'b1});

   a_r4_start_reload: assert property (@(posedge clk) disable iff (rst)
      (start && !seed_ld) |=> lfsr_q == $past(seed_r));

   a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
      (!en && !seed_ld && !start) |=> ($stable(chain_si) && $stable(lfsr_q)));

   a_r6_hold_only_selected: assert property (@(posedge clk) disable iff (rst)
      (en && !seed_ld && !start) |=> ((hold_q ^ $past(hold_q)) & ~$past(upd)) == '0);

   a_r9_full_rate: assert property (@(posedge clk) disable iff (rst)
      (en && !seed_ld && !start && target == '1) |=> hold_q == $past(lfsr_q[G-1:0]));
endmodule

bind ltp_prpg ltp_prpg_chk #(.LW(LW), .G(G), .TW(TW), .N(N)) u_chk (
   .clk(clk), .rst(rst), .en(en), .start(start), .seed_ld(seed_ld),
   .seed(seed), .target(target), .chain_si(chain_si), .lfsr_q(lfsr_q),
   .seed_r(seed_r), .hold_q(hold_q), .upd(upd)
);

// File: tb/tb_ltp_prpg.sv
module tb_ltp_prpg;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic        start = 1'b0;
   logic        seed_ld = 1'b0;
   logic [15:0] seed = '0;
   logic [3:0]  target = '0;
   logic [31:0] chain_si;

   int n_run = 0;
   int n_fail = 0;
   bit chk_on = 1'b0;
   string tag = "R1";

   // behavioural model state
   logic [15:0] m_seed, m_gen;
   logic [31:0] m_aux;
   logic [7:0]  m_h;

   always #4 clk = ~clk;

   ltp_prpg dut (
      .clk(clk), .rst(rst), .en(en), .start(start), .seed_ld(seed_ld),
      .seed(seed), .target(target), .chain_si(chain_si)
   );

   function automatic logic [31:0] expand(input logic [7:0] h);
      logic [31:0] r;
      for (int j = 0; j < 32; j++) begin
         int x = j % 8;
         int y = (x + 1 + j / 8) % 8;
         int z = (x + 5 + (j / 8) % 2) % 8;
         r[j] = h[x] ^ h[y];
         if (j >= 16) r[j] = r[j] ^ h[z];
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_int(input string req, input bit ok, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_seed = 16'hACE1; m_gen = 16'hACE1; m_aux = 32'hC0DE1357; m_h = 8'hE1;
      end else if (seed_ld) begin
         m_seed = (seed == 0) ? 16'd1 : seed;
         m_gen = m_seed; m_aux = 32'hC0DE1357; m_h = m_seed[7:0];
      end else if (start) begin
         m_gen = m_seed; m_aux = 32'hC0DE1357; m_h = m_seed[7:0];
      end else if (en) begin
         for (int i = 0; i < 8; i++)
            if (((m_aux >> (4 * i)) & 32'hF) <= 32'(target)) m_h[i] = m_gen[i];
         m_gen = {m_gen[14:0], m_gen[15] ^ m_gen[13] ^ m_gen[12] ^ m_gen[10]};
         m_aux = {m_aux[30:0], m_aux[31] ^ m_aux[21] ^ m_aux[1] ^ m_aux[0]};
      end
   end

   always @(negedge clk) begin
      if (chk_on && !rst) check(tag, chain_si, expand(m_h));
   end

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic restart_from_seed();
      start = 1'b1; step(1); start = 1'b0;
   endtask

   initial begin
      logic [31:0] snap, prev;
      int tog [5];
      int codes [5] = '{0, 3, 7, 11, 15};

      step(2);
      rst = 1'b0;
      step(1);
      // R1: reset state
      check("R1", chain_si, expand(8'hE1));
      chk_on = 1'b1;

      tag = "R2 R7 R8 full-rate";
      target = 4'd15; en = 1'b1; step(60);

      // R5: disabled cycles leave the output untouched
      en = 1'b0; step(1); snap = chain_si;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk); check("R5", chain_si, snap);
      end
      tag = "R6 R7 partial"; target = 4'd5; en = 1'b1; step(200);
      target = 4'd0; step(100);

      // R3: zero seed is stored as 1
      tag = "R3";
      seed = 16'h0; seed_ld = 1'b1; start = 1'b1; step(1); seed_ld = 1'b0; start = 1'b0;
      check("R3 zero seed", chain_si, expand(8'h01));
      target = 4'd15; step(30);

      seed = 16'h1234; seed_ld = 1'b1; step(1); seed_ld = 1'b0;
      check("R3 seed load", chain_si, expand(8'h34));
      target = 4'd9; step(40);

      // R4: start replays from the stored seed
      tag = "R4";
      restart_from_seed();
      check("R4 start", chain_si, expand(8'h34));
      step(40);

      // R9 / R10: toggle-rate measurement
      for (int c = 0; c < 5; c++) begin
         tag = "R6 R10 sweep";
         target = codes[c];
         restart_from_seed();
         prev = chain_si; tog[c] = 0;
         for (int k = 0; k < 4096; k++) begin
            @(negedge clk);
            tog[c] += $countones(chain_si ^ prev);
            prev = chain_si;
         end
      end
      for (int c = 1; c < 5; c++)
         check_int("R10 monotonic", tog[c] > tog[c-1], tog[c], tog[c-1] + 1);
      check_int("R9 full rate", tog[4] >= 58982 && tog[4] <= 72089, tog[4], 65536);

      chk_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule